// File: doc/BRIEF.md
# Two-State Survivor Path Memory (Register Exchange)

This block keeps the survivor sequences for a binary trellis with two states, such as the one a 1-D (dicode) channel produces, and turns them into a stream of decided bits. Each symbol period, the compare stage upstream hands it a two-bit selection code. The code says, for each state, whether the state continues its own history or inherits the history of the other state. Every stage of both survivor registers is a flip-flop behind a two-input multiplexer. When the two paths merge, one whole register is loaded in parallel from the other, and at the same time both registers shift.

After each update, the newest position of a register holds the index of that register's state. When a bit has travelled the full truncation depth, it reaches the oldest position and is presented as the decision. A synchronous flush empties both survivors and restarts the fill. An optional comparator flags any decision where the two survivors have not merged by the oldest position.

Top module: `survivor_exchange`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both survivor registers and leaves `outValid`, `outBit` and `outMismatch` at 0.
- R2: On every accepted update (`inValid` high, `flush` low), the newest position of the state-0 survivor receives 0 and the newest position of the state-1 survivor receives 1.
- R3: With `selCode` = 2'b00, each survivor shifts its own previous contents by one position toward the oldest end.
- R4: With `selCode` = 2'b01, both states take the state-0 history: the state-1 survivor is loaded from the shifted state-0 contents and then receives its newest bit.
- R5: With `selCode` = 2'b10, both states take the state-1 history: the state-0 survivor is loaded from the shifted state-1 contents and then receives its newest bit.
- R6: `selCode` = 2'b11 is illegal and behaves exactly like 2'b00.
- R7: A cycle with `inValid` low leaves both survivors unchanged and produces no `outValid` pulse.
- R8: `outValid` is high for one cycle after each accepted update once the update count since reset or flush reaches DEPTH. In that cycle `outBit` is the oldest bit of the state-0 survivor, which is the state-0 path's bit from DEPTH-1 updates earlier.
- R9: `outMismatch` is high only in an `outValid` cycle in which the oldest bits of the two survivors differ (CHECK_EN = 1).
- R10: `flush` clears both survivors and the fill count and takes priority over `inValid` in the same cycle. The first `outValid` after a flush follows the DEPTH-th accepted update after it.
- R11: The truncation depth DEPTH is a parameter (default 16; 12 and 17 are supported). No `outValid` appears during the first DEPTH-1 updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A selection code is present this cycle |
| selCode | input | 2 | 00 keep both, 01 both from state 0, 10 both from state 1, 11 treated as 00 |
| flush | input | 1 | Synchronous clear of the survivors and the fill count |
| outValid | output | 1 | Decision present on `outBit` |
| outBit | output | 1 | Oldest bit of the state-0 survivor |
| outMismatch | output | 1 | Oldest bits of the two survivors disagree (qualified by `outValid`) |

## Verification
The bench steps an unbounded path model and compares its expected decisions with the DUT output. It concentrates on the fill boundary. A counter off by one would raise `outValid` on update 15 or 17 instead of update 16, and the scoreboard would then find the queue empty or would find an item left over. Long runs of each merge code are driven. In such a run, a multiplexer wired to the wrong neighbour or the wrong register leaves stale history in the oldest position and gives wrong bits and wrong mismatch flags. Gaps in `inValid`, the illegal code 11, and a flush issued together with a valid symbol are also driven. A design that shifted during gaps, decoded 11 as a merge, or let the symbol through in the flush cycle would shift the decision stream or refill early.

// File: rtl/survivor_pkg.sv
package survivor_pkg;
  typedef enum logic [1:0] {
    SEL_KEEP  = 2'b00,
    SEL_FROM0 = 2'b01,
    SEL_FROM1 = 2'b10,
    SEL_BAD   = 2'b11
  } selCode_e;

  typedef struct packed {
    logic shift;     // accepted update this cycle
    logic clear;     // flush request
    logic take1For0; // state 0 inherits state-1 history
    logic take0For1; // state 1 inherits state-0 history
  } pmStrobe_t;
endpackage

// File: rtl/survivor_ctrl.sv
module survivor_ctrl
  import survivor_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic [1:0] selCode,
  input  logic      flush,
  output pmStrobe_t strobe,
  output logic      outValid
);
  localparam int CW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH - 1);

  logic [CW-1:0] fillCnt;
  selCode_e      code;

  assign code = selCode_e'(selCode);

  always_comb begin
    strobe           = '0;
    strobe.clear     = flush;
    strobe.shift     = inValid && !flush;
    strobe.take1For0 = strobe.shift && (code == SEL_FROM1);
    strobe.take0For1 = strobe.shift && (code == SEL_FROM0);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      fillCnt  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= inValid && (fillCnt == FULL);
      if (inValid && fillCnt != FULL) fillCnt <= fillCnt + 1'b1;
    end
  end

  // R6: the illegal code never requests a merge
  p_illegal_code_r6: assert property (@(posedge clk) disable iff (rst)
    (selCode == 2'b11) |-> !(strobe.take1For0 || strobe.take0For1));
  // R10: a flush always silences the next cycle
  p_flush_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> !outValid);
  // R8/R7: a decision only follows an accepted update
  p_valid_cause_r8: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid && !flush));
endmodule

// File: rtl/survivor_path.sv
module survivor_path
  import survivor_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  pmStrobe_t strobe,
  output logic      oldest0,
  output logic      oldest1
);
  logic [DEPTH-1:0] surv0, surv1;
  logic [DEPTH-1:0] next0, next1;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign next0[0] = 1'b0;
      assign next1[0] = 1'b1;
    end else begin : g_body
      assign next0[i] = strobe.take1For0 ? surv1[i-1] : surv0[i-1];
      assign next1[i] = strobe.take0For1 ? surv0[i-1] : surv1[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      surv0 <= '0;
      surv1 <= '0;
    end else if (strobe.shift) begin
      surv0 <= next0;
      surv1 <= next1;
    end
  end

  assign oldest0 = surv0[DEPTH-1];
  assign oldest1 = surv1[DEPTH-1];

  // R2: newest positions carry the state index
  p_newest_bits_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.shift |=> (surv0[0] == 1'b0) && (surv1[0] == 1'b1));
  // R3: without merge each survivor moves its own contents
  p_own_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe.shift && !strobe.take1For0 && !strobe.take0For1) |=>
      (surv0[DEPTH-1:1] == $past(surv0[DEPTH-2:0])) &&
      (surv1[DEPTH-1:1] == $past(surv1[DEPTH-2:0])));
  // R4: state-1 survivor overwritten by state-0 history
  p_merge_from0_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe.shift && strobe.take0For1) |=> surv1[DEPTH-1:1] == surv0[DEPTH-1:1]);
  // R5: state-0 survivor overwritten by state-1 history
  p_merge_from1_r5: assert property (@(posedge clk) disable iff (rst)
    (strobe.shift && strobe.take1For0) |=> surv0[DEPTH-1:1] == surv1[DEPTH-1:1]);
  // R7: idle cycles hold both survivors
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!strobe.shift && !strobe.clear) |=> $stable(surv0) && $stable(surv1));
  // R10: flush empties both survivors
  p_flush_clear_r10: assert property (@(posedge clk) disable iff (rst)
    strobe.clear |=> (surv0 == '0) && (surv1 == '0));
endmodule

// File: rtl/survivor_exchange.sv
module survivor_exchange
  import survivor_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter bit CHECK_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] selCode,
  input  logic       flush,
  output logic       outValid,
  output logic       outBit,
  output logic       outMismatch
);
  pmStrobe_t strobe;
  logic      oldest0, oldest1;

  survivor_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .selCode(selCode),
    .flush(flush), .strobe(strobe), .outValid(outValid)
  );

  survivor_path #(.DEPTH(DEPTH)) u_path (
    .clk(clk), .rst(rst), .strobe(strobe),
    .oldest0(oldest0), .oldest1(oldest1)
  );

  assign outBit = oldest0;

  if (CHECK_EN) begin : g_check
    assign outMismatch = outValid && (oldest0 != oldest1);
  end else begin : g_nocheck
    assign outMismatch = 1'b0;
  end

  // R9: the flag never appears without a decision
  p_flag_qualified_r9: assert property (@(posedge clk) disable iff (rst)
    outMismatch |-> outValid);
  // R11: depth must leave room for a body stage
  initial begin
    a_depth_r11: assert (DEPTH >= 2);
  end
endmodule

// File: tb/sim_survivor_exchange.sv
module sim_survivor_exchange;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [1:0] selCode = 2'b00;
  logic flush = 1'b0;
  logic outValid, outBit, outMismatch;

  int checks = 0;
  int failures = 0;
  int validSeen = 0;
  bit done = 1'b0;

  bit    p0[$];
  bit    p1[$];
  bit    expB[$];
  bit    expM[$];
  string expT[$];
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  survivor_exchange #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .selCode(selCode),
    .flush(flush), .outValid(outValid), .outBit(outBit),
    .outMismatch(outMismatch)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // driver: one symbol, reference path update, expected push
  task automatic sendSym(input bit v, input logic [1:0] s, input string tag);
    bit n0[$];
    bit n1[$];
    int k;
    @(negedge clk);
    inValid = v;
    selCode = s;
    if (v) begin
      n0 = (s == 2'b10) ? p1 : p0;
      n1 = (s == 2'b01) ? p0 : p1;
      n0.push_back(1'b0);
      n1.push_back(1'b1);
      p0 = n0;
      p1 = n1;
      k = p0.size();
      if (k >= DEPTH) begin
        expB.push_back(p0[k-DEPTH]);
        expM.push_back(p0[k-DEPTH] != p1[k-DEPTH]);
        expT.push_back(tag);
      end
    end
  endtask

  // monitor: pops and compares each decision
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst) begin
        if (outValid) begin
          validSeen++;
          if (expB.size() == 0) begin
            check(1'b0, "R8/R11 unexpected outValid", 1, 0);
          end else begin
            string t;
            bit eb, em;
            eb = expB.pop_front();
            em = expM.pop_front();
            t = expT.pop_front();
            check(outBit == eb, {t, " R8 outBit"}, outBit, eb);
            check(outMismatch == em, {t, " R9 outMismatch"}, outMismatch, em);
          end
        end else begin
          check(outMismatch == 1'b0, "R9 flag without outValid", outMismatch, 0);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(outValid == 1'b0, "R1 reset outValid", outValid, 0);
    check(outBit == 1'b0, "R1 reset outBit", outBit, 0);
    check(outMismatch == 1'b0, "R1 reset outMismatch", outMismatch, 0);
    @(negedge clk);
    rst = 1'b0;

    // fill boundary with independent shifting
    for (int i = 0; i < DEPTH - 1; i++) sendSym(1'b1, 2'b00, "R2 R3");
    sendSym(1'b0, 2'b00, "R7");
    @(negedge clk); #2;
    check(validSeen == 0, "R11 no outValid before DEPTH updates", validSeen, 0);
    sendSym(1'b1, 2'b00, "R2 R3");
    sendSym(1'b0, 2'b00, "R7");
    #2;
    check(validSeen == 1, "R11 first outValid at DEPTH-th update", validSeen, 1);
    for (int i = 0; i < 20; i++) sendSym(1'b1, 2'b00, "R2 R3");

    for (int i = 0; i < 20; i++) sendSym(1'b1, 2'b01, "R4");
    for (int i = 0; i < 20; i++) sendSym(1'b1, 2'b10, "R5");
    for (int i = 0; i < 6; i++) sendSym(1'b1, (i % 2 == 0) ? 2'b01 : 2'b10, "R4 R5");
    for (int i = 0; i < 20; i++) sendSym(1'b1, 2'b11, "R6");

    // mixed codes with gaps
    for (int i = 0; i < 200; i++) begin
      lfsr = step(lfsr);
      sendSym(lfsr[0] | lfsr[3], lfsr[5:4], "R7 R3 R4 R5 R6");
    end

    // flush together with a valid symbol
    @(negedge clk);
    flush = 1'b1;
    inValid = 1'b1;
    selCode = 2'b10;
    p0.delete();
    p1.delete();
    @(negedge clk);
    flush = 1'b0;
    inValid = 1'b0;
    #2;
    check(outValid == 1'b0, "R10 outValid after flush", outValid, 0);
    validSeen = 0;
    for (int i = 0; i < 80; i++) begin
      lfsr = step(lfsr);
      sendSym(1'b1, lfsr[2:1], "R10");
    end
    sendSym(1'b0, 2'b00, "R7");
    repeat (3) @(negedge clk);
    #2;
    check(validSeen == 80 - DEPTH + 1, "R10 R11 decisions after flush", validSeen, 80 - DEPTH + 1);
    check(expB.size() == 0, "R8 all expected decisions produced", expB.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule